// File: doc/BRIEF.md
# Single-Bank DRAM Command Sequencer

This block sits between a request source and the command/address pins of one DRAM bank. It accepts one read or write request at a time, each carrying a row and a column address. It compares the requested row with the row held in the bank's row buffer and sorts the request into one of three classes. A hit needs only the column command. An empty bank needs an activate first. A conflict needs a precharge, then an activate, then the column command. The block issues exactly the steps the class needs, each at the first cycle the bank's timing allows. After an access the row is left open, so a later access to the same row is a hit.

Four independent down-counters enforce the minimum spacing between commands: activate to column, precharge to activate, activate to precharge, and activate to activate. A delay line of column-latency length produces a one-cycle data-valid strobe for every column command. A free-running interval counter raises a refresh request. Refresh takes priority over new requests and runs as an optional precharge, then an activate of the next row in a refresh sequence, then a closing precharge. After a refresh the bank has no row open.

Top module: `dram_bank_sched`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the command output is NOP with address 0, reqReady is high, and dataValid and classValid are low.
- R2: reqReady is low in every cycle from the cycle after a request is accepted up to, but not including, the cycle in which that request's column command appears. Only one request is in progress at a time.
- R3: classValid pulses high for exactly one cycle, in the cycle after each accepted request. classCode gives the class, judged against the row open when the request was accepted: 1 = hit (same row open), 2 = empty (no row open), 3 = conflict (another row open).
- R4: A hit issues only the column command, in cycle max(accept+2, lastACT+T_RCD).
- R5: An empty request issues ACT with the requested row, then the column command. Each command appears in the earliest cycle allowed by R7 to R9, and no earlier than one cycle after the previous step (the first step no earlier than accept+2).
- R6: A conflict issues PRE, then ACT, then the column command, with the same earliest-cycle rule as R5.
- R7: A PRE appears only while a row is open, and at least T_RAS cycles after the most recent ACT.
- R8: An ACT appears only while no row is open, at least T_RP cycles after the most recent PRE and at least T_RC cycles after the previous ACT.
- R9: A column command appears only while the requested row is open, at least T_RCD cycles after that ACT, and cmdAddr carries the column.
- R10: dataValid is high for one cycle exactly T_CAS cycles after each RD or WR appears. In that cycle dataWrite is 1 for a WR and 0 for a RD.
- R11: Every REF_INT cycles a refresh becomes pending. While it is pending reqReady is low. The refresh then runs: a PRE if a row is open, an ACT whose address steps through 0, 1, 2, ... and wraps modulo 2^ROW_W, and a closing PRE. All of these obey R7 and R8. No request is accepted between the refresh ACT and its closing PRE.
- R12: cmdCode encodes NOP=0, ACT=1, PRE=2, RD=3, WR=4, with no other value. cmdAddr is 0 on NOP and PRE. It carries the row on ACT and the column on RD/WR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Request can be accepted this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqRow | input | ROW_W | Requested row |
| reqCol | input | COL_W | Requested column |
| cmdCode | output | 3 | Command to the bank (R12 encoding) |
| cmdAddr | output | max(ROW_W,COL_W) | Row or column address for the command |
| dataValid | output | 1 | Data beat strobe, T_CAS after a column command |
| dataWrite | output | 1 | Direction of the current data beat |
| classValid | output | 1 | Classification strobe |
| classCode | output | 2 | Hit, empty or conflict (R3 encoding) |

## Verification
The spacing assertions assume that the bank state starts closed after reset and that every command reaching the pins comes from this block. They also assume the request source holds reqRow, reqCol and reqWrite steady while reqValid waits for reqReady. The stimulus follows this by changing inputs only shortly after a rising edge and dropping reqValid right after the handshake. The sweep runs every pair of consecutive rows with idle gaps of zero to two cycles. This produces hits, empties and conflicts both right after an activate (so the earliest-cycle rule binds on T_RAS, T_RC and T_RCD) and well after one. Because the refresh interval is short, refreshes land both with a row open and with the bank closed, and they sometimes hold off a waiting request.

// File: rtl/dram_bank_pkg.sv
package dram_bank_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_PRE = 3'd2,
    CMD_RD  = 3'd3,
    CMD_WR  = 3'd4
  } cmd_e;

  typedef enum logic [1:0] {
    CLS_NONE     = 2'd0,
    CLS_HIT      = 2'd1,
    CLS_EMPTY    = 2'd2,
    CLS_CONFLICT = 2'd3
  } rowcls_e;

  // strobes from control to datapath, all single-cycle
  typedef struct packed {
    logic accept;
    logic refStart;
    logic issuePre;
    logic issueAct;
    logic issueCol;
    logic useRefRow;
  } ctrl_strb_t;

  localparam int N_GAP   = 4;
  localparam int GAP_RCD = 0;
  localparam int GAP_RP  = 1;
  localparam int GAP_RAS = 2;
  localparam int GAP_RC  = 3;

endpackage

// File: rtl/dram_gap_timer.sv
module dram_gap_timer #(
  parameter int LIMIT = 4,
  parameter int CW    = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic ok
);
  logic [CW-1:0] cnt;

  // loaded with LIMIT-1 when the triggering command is decided; that
  // command reaches the pins one cycle later, so the next decision at
  // cnt==0 lands exactly LIMIT cycles after it on the pins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (start)       cnt <= CW'(LIMIT - 1);
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign ok = (cnt == '0);
endmodule

// File: rtl/dram_bank_dp.sv
module dram_bank_dp
  import dram_bank_pkg::*;
#(
  parameter int ROW_W   = 3,
  parameter int COL_W   = 4,
  parameter int ADDR_W  = 4,
  parameter int T_CAS   = 3,
  parameter int T_RCD   = 3,
  parameter int T_RP    = 3,
  parameter int T_RAS   = 6,
  parameter int T_RC    = 9,
  parameter int REF_INT = 180
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrl_strb_t        strb,
  input  logic [ROW_W-1:0]  reqRow,
  input  logic [COL_W-1:0]  reqCol,
  input  logic              reqWrite,
  output rowcls_e           reqClass,
  output logic              rowOpen,
  output logic [N_GAP-1:0]  gapOk,
  output logic              refPending,
  output logic [2:0]        cmdCode,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic              dataValid,
  output logic              dataWrite,
  output logic              classValid,
  output logic [1:0]        classCode
);
  localparam int MAX_A = (T_RCD > T_RP) ? T_RCD : T_RP;
  localparam int MAX_B = (T_RAS > T_RC) ? T_RAS : T_RC;
  localparam int MAXT  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CW    = $clog2(MAXT + 1);
  localparam int RFW   = $clog2(REF_INT + 1);
  localparam int GAP_LIM [N_GAP] = '{T_RCD, T_RP, T_RAS, T_RC};

  logic [ROW_W-1:0] openRow, pendRow, refRow, actRow;
  logic [COL_W-1:0] pendCol;
  logic             pendWrite;
  logic [RFW-1:0]   refCnt;
  logic             refExpire;
  logic [N_GAP-1:0] gapStart;

  // ---- classification of the offered request against the open row
  always_comb begin
    if (!rowOpen)                reqClass = CLS_EMPTY;
    else if (openRow == reqRow)  reqClass = CLS_HIT;
    else                         reqClass = CLS_CONFLICT;
  end

  // ---- per-constraint spacing counters
  always_comb begin
    gapStart          = '0;
    gapStart[GAP_RCD] = strb.issueAct;
    gapStart[GAP_RP]  = strb.issuePre;
    gapStart[GAP_RAS] = strb.issueAct;
    gapStart[GAP_RC]  = strb.issueAct;
  end

  for (genvar g = 0; g < N_GAP; g++) begin : g_gap
    dram_gap_timer #(.LIMIT(GAP_LIM[g]), .CW(CW)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .start (gapStart[g]),
      .ok    (gapOk[g])
    );
  end

  // ---- request latch and row-buffer state
  assign actRow = strb.useRefRow ? refRow : pendRow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pendRow   <= '0;
      pendCol   <= '0;
      pendWrite <= 1'b0;
      rowOpen   <= 1'b0;
      openRow   <= '0;
    end else begin
      if (strb.accept) begin
        pendRow   <= reqRow;
        pendCol   <= reqCol;
        pendWrite <= reqWrite;
      end
      if (strb.issueAct) begin
        rowOpen <= 1'b1;
        openRow <= actRow;
      end else if (strb.issuePre) begin
        rowOpen <= 1'b0;
      end
    end
  end

  // ---- refresh interval and refresh row sequence
  assign refExpire = (refCnt == RFW'(REF_INT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      refCnt     <= '0;
      refPending <= 1'b0;
      refRow     <= '0;
    end else begin
      refCnt     <= refExpire ? '0 : refCnt + 1'b1;
      refPending <= (refPending & ~strb.refStart) | refExpire;
      if (strb.issueAct && strb.useRefRow) refRow <= refRow + 1'b1;
    end
  end

  // ---- registered command/address output
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmdCode <= CMD_NOP;
      cmdAddr <= '0;
    end else if (strb.issueAct) begin
      cmdCode <= CMD_ACT;
      cmdAddr <= ADDR_W'(actRow);
    end else if (strb.issuePre) begin
      cmdCode <= CMD_PRE;
      cmdAddr <= '0;
    end else if (strb.issueCol) begin
      cmdCode <= pendWrite ? CMD_WR : CMD_RD;
      cmdAddr <= ADDR_W'(pendCol);
    end else begin
      cmdCode <= CMD_NOP;
      cmdAddr <= '0;
    end
  end

  // ---- classification strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      classValid <= 1'b0;
      classCode  <= CLS_NONE;
    end else begin
      classValid <= strb.accept;
      classCode  <= strb.accept ? reqClass : CLS_NONE;
    end
  end

  // ---- column-latency delay line fed from the pins
  logic             colOut, wrOut;
  logic [T_CAS-1:0] dvSr, dwSr;

  assign colOut = (cmdCode == CMD_RD) || (cmdCode == CMD_WR);
  assign wrOut  = (cmdCode == CMD_WR);

  if (T_CAS == 1) begin : g_cas_one
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dvSr <= '0;
        dwSr <= '0;
      end else begin
        dvSr <= colOut;
        dwSr <= wrOut;
      end
    end
  end else begin : g_cas_multi
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dvSr <= '0;
        dwSr <= '0;
      end else begin
        dvSr <= {dvSr[T_CAS-2:0], colOut};
        dwSr <= {dwSr[T_CAS-2:0], wrOut};
      end
    end
  end

  assign dataValid = dvSr[T_CAS-1];
  assign dataWrite = dwSr[T_CAS-1];
endmodule

// File: rtl/dram_bank_ctrl.sv
module dram_bank_ctrl
  import dram_bank_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reqValid,
  input  rowcls_e          reqClass,
  input  logic             rowOpen,
  input  logic [N_GAP-1:0] gapOk,
  input  logic             refPending,
  output logic             reqReady,
  output ctrl_strb_t       strb
);
  typedef enum logic [2:0] {
    S_IDLE, S_PRE, S_ACT, S_COL, S_RPRE, S_RACT, S_RCLOSE
  } state_e;

  state_e state, nxt;
  logic   actOk;

  assign actOk    = gapOk[GAP_RP] && gapOk[GAP_RC];
  assign reqReady = (state == S_IDLE) && !refPending;

  always_comb begin
    nxt  = state;
    strb = '0;
    unique case (state)
      S_IDLE: begin
        if (refPending) begin
          strb.refStart = 1'b1;
          nxt = rowOpen ? S_RPRE : S_RACT;
        end else if (reqValid) begin
          strb.accept = 1'b1;
          unique case (reqClass)
            CLS_HIT:   nxt = S_COL;
            CLS_EMPTY: nxt = S_ACT;
            default:   nxt = S_PRE;
          endcase
        end
      end
      S_PRE: if (gapOk[GAP_RAS]) begin
        strb.issuePre = 1'b1;
        nxt = S_ACT;
      end
      S_ACT: if (actOk) begin
        strb.issueAct = 1'b1;
        nxt = S_COL;
      end
      S_COL: if (gapOk[GAP_RCD]) begin
        strb.issueCol = 1'b1;
        nxt = S_IDLE;
      end
      S_RPRE: if (gapOk[GAP_RAS]) begin
        strb.issuePre = 1'b1;
        nxt = S_RACT;
      end
      S_RACT: if (actOk) begin
        strb.issueAct  = 1'b1;
        strb.useRefRow = 1'b1;
        nxt = S_RCLOSE;
      end
      S_RCLOSE: if (gapOk[GAP_RAS]) begin
        strb.issuePre = 1'b1;
        nxt = S_IDLE;
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= S_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/dram_bank_sched.sv
module dram_bank_sched
  import dram_bank_pkg::*;
#(
  parameter int ROW_W   = 3,
  parameter int COL_W   = 4,
  parameter int T_CAS   = 3,
  parameter int T_RCD   = 3,
  parameter int T_RP    = 3,
  parameter int T_RAS   = 6,
  parameter int T_RC    = T_RAS + T_RP,
  parameter int REF_INT = 180,
  localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ROW_W-1:0]  reqRow,
  input  logic [COL_W-1:0]  reqCol,
  output logic [2:0]        cmdCode,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic              dataValid,
  output logic              dataWrite,
  output logic              classValid,
  output logic [1:0]        classCode
);
  ctrl_strb_t       strb;
  rowcls_e          reqClass;
  logic             rowOpen;
  logic [N_GAP-1:0] gapOk;
  logic             refPending;

  dram_bank_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .reqValid   (reqValid),
    .reqClass   (reqClass),
    .rowOpen    (rowOpen),
    .gapOk      (gapOk),
    .refPending (refPending),
    .reqReady   (reqReady),
    .strb       (strb)
  );

  dram_bank_dp #(
    .ROW_W(ROW_W), .COL_W(COL_W), .ADDR_W(ADDR_W), .T_CAS(T_CAS),
    .T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS), .T_RC(T_RC), .REF_INT(REF_INT)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strb       (strb),
    .reqRow     (reqRow),
    .reqCol     (reqCol),
    .reqWrite   (reqWrite),
    .reqClass   (reqClass),
    .rowOpen    (rowOpen),
    .gapOk      (gapOk),
    .refPending (refPending),
    .cmdCode    (cmdCode),
    .cmdAddr    (cmdAddr),
    .dataValid  (dataValid),
    .dataWrite  (dataWrite),
    .classValid (classValid),
    .classCode  (classCode)
  );
endmodule

// File: rtl/dram_bank_sched_chk.sv
module dram_bank_sched_chk
  import dram_bank_pkg::*;
#(
  parameter int T_RCD = 3,
  parameter int T_RP  = 3,
  parameter int T_RAS = 6,
  parameter int T_RC  = 9
) (
  input logic       clk,
  input logic       rst_n,
  input logic       reqValid,
  input logic       reqReady,
  input logic [2:0] cmdCode,
  input logic       classValid,
  input logic       refPending
);
  localparam int MAX_A = (T_RCD > T_RP) ? T_RCD : T_RP;
  localparam int MAX_B = (T_RAS > T_RC) ? T_RAS : T_RC;
  localparam int SAT   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int AW    = $clog2(SAT + 1);

  logic [AW-1:0] actAge, preAge;
  logic          isCol;

  assign isCol = (cmdCode == CMD_RD) || (cmdCode == CMD_WR);

  // cycles since the last ACT / PRE seen on the pins, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      actAge <= AW'(SAT);
      preAge <= AW'(SAT);
    end else begin
      if (cmdCode == CMD_ACT)      actAge <= AW'(1);
      else if (actAge < AW'(SAT))  actAge <= actAge + 1'b1;
      if (cmdCode == CMD_PRE)      preAge <= AW'(1);
      else if (preAge < AW'(SAT))  preAge <= preAge + 1'b1;
    end
  end

  p_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && reqReady) |=> !reqReady);

  p_class_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && reqReady) |=> classValid);

  p_pre_tras_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdCode == CMD_PRE) |-> (actAge >= AW'(T_RAS)));

  p_act_trp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdCode == CMD_ACT) |-> (preAge >= AW'(T_RP)));

  p_act_trc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdCode == CMD_ACT) |-> (actAge >= AW'(T_RC)));

  p_col_trcd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    isCol |-> (actAge >= AW'(T_RCD)));

  p_ref_block_r11: assert property (@(posedge clk) disable iff (!rst_n)
    refPending |-> !reqReady);

  p_cmd_legal_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cmdCode <= 3'd4);
endmodule

bind dram_bank_sched dram_bank_sched_chk #(
  .T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS), .T_RC(T_RC)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reqValid   (reqValid),
  .reqReady   (reqReady),
  .cmdCode    (cmdCode),
  .classValid (classValid),
  .refPending (refPending)
);

// File: tb/dram_bank_sched_test.sv
`timescale 1ns/100ps
module dram_bank_sched_test;
  localparam int ROW_W   = 3;
  localparam int COL_W   = 4;
  localparam int T_CAS   = 3;
  localparam int T_RCD   = 3;
  localparam int T_RP    = 3;
  localparam int T_RAS   = 6;
  localparam int T_RC    = 9;
  localparam int REF_INT = 180;
  localparam int ROWS    = 1 << ROW_W;
  localparam int ADDR_W  = (ROW_W > COL_W) ? ROW_W : COL_W;

  // R12 command codes, R3 class codes
  localparam int C_NOP = 0, C_ACT = 1, C_PRE = 2, C_RD = 3, C_WR = 4;
  localparam int K_HIT = 1, K_EMPTY = 2, K_CONF = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              reqValid = 1'b0;
  logic              reqReady;
  logic              reqWrite = 1'b0;
  logic [ROW_W-1:0]  reqRow = '0;
  logic [COL_W-1:0]  reqCol = '0;
  logic [2:0]        cmdCode;
  logic [ADDR_W-1:0] cmdAddr;
  logic              dataValid, dataWrite, classValid;
  logic [1:0]        classCode;

  dram_bank_sched #(
    .ROW_W(ROW_W), .COL_W(COL_W), .T_CAS(T_CAS), .T_RCD(T_RCD), .T_RP(T_RP),
    .T_RAS(T_RAS), .T_RC(T_RC), .REF_INT(REF_INT)
  ) uut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqRow(reqRow), .reqCol(reqCol),
    .cmdCode(cmdCode), .cmdAddr(cmdAddr), .dataValid(dataValid),
    .dataWrite(dataWrite), .classValid(classValid), .classCode(classCode)
  );

  always #2.5 clk = ~clk;

  int  nChecks = 0, nFail = 0, cyc = 0;
  bit  monOn = 1'b0, finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cyc, act, exp);
    end
  endtask

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  endtask

  // ---- bench model of the bank, built from the pins
  bit dvExp [64];
  bit dwExp [64];
  int lastAct = -1000, lastPre = -1000, stepPrev = 0, accC = 0, clsDue = -5;
  bit openB = 1'b0, busy = 1'b0, refOpen = 1'b0, pWr = 1'b0;
  int openRowB = 0, pRow = 0, pCol = 0, pCls = 0, refRowB = 0, refActs = 0;
  int c, e;

  initial for (int i = 0; i < 64; i++) begin dvExp[i] = 1'b0; dwExp[i] = 1'b0; end

  always @(negedge clk) begin
    if (monOn && !finished) begin
      c = cyc;
      // R10 data strobe
      chk(dataValid == dvExp[c % 64], "R10 dataValid", int'(dataValid), int'(dvExp[c % 64]));
      if (dataValid)
        chk(dataWrite == dwExp[c % 64], "R10 dataWrite", int'(dataWrite), int'(dwExp[c % 64]));
      dvExp[c % 64] = 1'b0;
      // R3 classification strobe
      chk(classValid == (c == clsDue), "R3 classValid", int'(classValid), int'(c == clsDue));
      if (classValid) chk(int'(classCode) == pCls, "R3 classCode", int'(classCode), pCls);

      case (int'(cmdCode))
        C_NOP: chk(cmdAddr == '0, "R12 NOP addr", int'(cmdAddr), 0);
        C_ACT: begin
          chk(!openB, "R8 ACT with row open", int'(openB), 0);
          chk(c - lastPre >= T_RP, "R8 tRP", c - lastPre, T_RP);
          chk(c - lastAct >= T_RC, "R8 tRC", c - lastAct, T_RC);
          if (busy) begin
            e = mx(stepPrev + 1, mx(lastPre + T_RP, lastAct + T_RC));
            chk(pCls != K_HIT, "R4 ACT on hit", pCls, K_HIT);
            chk(c == e, "R5 ACT cycle", c, e);
            chk(int'(cmdAddr) == pRow, "R5 ACT row", int'(cmdAddr), pRow);
          end else begin
            chk(int'(cmdAddr) == refRowB, "R11 refresh row", int'(cmdAddr), refRowB);
            refRowB = (refRowB + 1) % ROWS;
            refActs++;
            refOpen = 1'b1;
          end
          openB = 1'b1; openRowB = int'(cmdAddr); lastAct = c; stepPrev = c;
        end
        C_PRE: begin
          chk(openB, "R7 PRE with no row open", int'(openB), 1);
          chk(c - lastAct >= T_RAS, "R7 tRAS", c - lastAct, T_RAS);
          chk(cmdAddr == '0, "R12 PRE addr", int'(cmdAddr), 0);
          if (busy) begin
            e = mx(stepPrev + 1, lastAct + T_RAS);
            chk(pCls == K_CONF, "R6 PRE only on conflict", pCls, K_CONF);
            chk(c == e, "R6 PRE cycle", c, e);
          end else refOpen = 1'b0;
          openB = 1'b0; lastPre = c; stepPrev = c;
        end
        C_RD, C_WR: begin
          chk(busy, "R9 column without request", int'(busy), 1);
          chk(openB && openRowB == pRow, "R9 column row", openRowB, pRow);
          chk(c - lastAct >= T_RCD, "R9 tRCD", c - lastAct, T_RCD);
          chk(int'(cmdAddr) == pCol, "R9 column addr", int'(cmdAddr), pCol);
          chk((int'(cmdCode) == C_WR) == pWr, "R12 RD/WR code", int'(cmdCode), pWr ? C_WR : C_RD);
          e = mx(stepPrev + 1, lastAct + T_RCD);
          chk(c == e, "R4 column cycle", c, e);
          dvExp[(c + T_CAS) % 64] = 1'b1;
          dwExp[(c + T_CAS) % 64] = (int'(cmdCode) == C_WR);
          busy = 1'b0;
        end
        default: chk(1'b0, "R12 illegal code", int'(cmdCode), 0);
      endcase

      if (busy && c > accC) chk(!reqReady, "R2 ready while busy", int'(reqReady), 0);

      if (reqValid && reqReady) begin
        chk(!refOpen, "R11 accept inside refresh", int'(refOpen), 0);
        busy = 1'b1; accC = c; stepPrev = c + 1; clsDue = c + 1;
        pRow = int'(reqRow); pCol = int'(reqCol); pWr = reqWrite;
        pCls = !openB ? K_EMPTY : (openRowB == int'(reqRow) ? K_HIT : K_CONF);
      end
    end
  end

  // ---- stimulus (inputs change 1 ns after a rising edge)
  task automatic doReq(input int row, input int col, input bit wr);
    reqValid = 1'b1; reqRow = ROW_W'(row); reqCol = COL_W'(col); reqWrite = wr;
    while (!reqReady) begin @(posedge clk); #1; end
    @(posedge clk); #1;
    reqValid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin @(posedge clk); #1; end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 during reset
    chk(int'(cmdCode) == C_NOP && cmdAddr == '0, "R1 cmd in reset", int'(cmdCode), C_NOP);
    chk(reqReady, "R1 ready in reset", int'(reqReady), 1);
    chk(!dataValid && !classValid, "R1 strobes in reset", int'(dataValid) + int'(classValid), 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    monOn = 1'b1;
    @(negedge clk);
    chk(int'(cmdCode) == C_NOP, "R1 cmd after reset", int'(cmdCode), C_NOP);
    chk(reqReady, "R1 ready after reset", int'(reqReady), 1);
    @(posedge clk); #1;

    // sweep every ordered row pair with small gaps and both directions
    for (int r1 = 0; r1 < ROWS; r1++)
      for (int r2 = 0; r2 < ROWS; r2++)
        for (int g = 0; g < 3; g++) begin
          doReq(r1, (r1 * 5 + r2) % 16, g[0]);
          idle(g);
          doReq(r2, (r2 * 3 + g) % 16, !g[0]);
          idle(g);
        end
    // long idle: refreshes with the bank closed, then repeat hits
    idle(2 * REF_INT + 20);
    for (int k = 0; k < 6; k++) doReq(5, k, k[0]);
    idle(40);

    // R11 refresh rate
    chk(refActs >= cyc / REF_INT - 1 && refActs <= cyc / REF_INT,
        "R11 refresh count", refActs, cyc / REF_INT);
    chk(!busy, "R2 request left in progress", int'(busy), 0);
    finishRun();
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL R2 watchdog expired: actual=%0d expected=%0d", cyc, 0);
    finishRun();
  end
endmodule